// File: doc/BRIEF.md
# Multichannel DMA Request Generator

This block produces a pair of DMA handshake request lines, one for reads and one for writes, for each channel of a multichannel serial port that runs without its FIFO buffer. A read request tells the DMA controller that a channel's receive data register holds a new word to be fetched. A write request tells it that the channel's transmit data register is empty and can take a word.

Each request is qualified by the channel enable and by its own per-channel DMA mask bit. A request is withdrawn by the bus access that services it: a completed read of the receive register, or a completed load of the transmit register. There is no separate acknowledge. After such an access the line is held low for one extra cycle, so that the register-state flag has time to update and a single access is never counted twice. Software clears the mask bits when it wants the receive and transmit interrupts, rather than DMA, to mark the end of a transfer.

All outputs are registered. The channels are fully independent and there is no arbitration between them.

Top module: `dma_req_gen`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released with no qualifying input, every bit of `dma_rd_req` and `dma_wr_req` is 0.
- R2: `dma_rd_req[i]` is 1 on the clock edge after `chan_en[i]`, `rd_dma_en[i]` and `rx_full[i]` are all 1, provided no completed receive read (`rx_rd_done[i]`) was seen on that edge or on the edge before it.
- R3: `dma_wr_req[i]` is 1 on the clock edge after `chan_en[i]`, `wr_dma_en[i]` and `tx_empty[i]` are all 1, provided no completed transmit load (`tx_ld_done[i]`) was seen on that edge or on the edge before it.
- R4: When `rd_dma_en[i]` is 0, `dma_rd_req[i]` is 0 on the next edge, even while `rx_full[i]` stays 1.
- R5: When `wr_dma_en[i]` is 0, `dma_wr_req[i]` is 0 on the next edge, even while `tx_empty[i]` stays 1.
- R6: When `chan_en[i]` is 0, both requests of channel i are 0 on the next edge.
- R7: A 1 on `rx_rd_done[i]` forces `dma_rd_req[i]` to 0 on the next two edges. If the read conditions still hold, the request returns on the third edge.
- R8: A 1 on `tx_ld_done[i]` forces `dma_wr_req[i]` to 0 on the next two edges. If the write conditions still hold, the request returns on the third edge.
- R9: Inputs of one channel have no effect on the request lines of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | NCH | Channel enable, one bit per channel |
| rd_dma_en | input | NCH | Per-channel DMA read mask (1 = enabled) |
| wr_dma_en | input | NCH | Per-channel DMA write mask (1 = enabled) |
| rx_full | input | NCH | Receive data register holds an unread word |
| tx_empty | input | NCH | Transmit data register is empty |
| rx_rd_done | input | NCH | One-cycle strobe: bus read of the receive register completed |
| tx_ld_done | input | NCH | One-cycle strobe: bus load of the transmit register completed |
| dma_rd_req | output | NCH | DMA read request lines |
| dma_wr_req | output | NCH | DMA write request lines |

## Verification
The read and write paths are each driven with every qualifier high, and then with a single qualifier low: the mask bit, the channel enable or the data flag. This separates a request that is correctly gated from one that ignores one of its terms. A completion strobe is pulsed while the data flag stays high, and the request is sampled on each of the following three edges. This distinguishes a correct two-edge holdoff from a missing holdoff, an overlong one and a request that never comes back. A strobe on one channel while a neighbour is requesting shows whether channels leak into each other.

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] rd_dma_en,
  input  logic [NCH-1:0] wr_dma_en,
  input  logic [NCH-1:0] rx_full,
  input  logic [NCH-1:0] tx_empty,
  input  logic [NCH-1:0] rx_rd_done,
  input  logic [NCH-1:0] tx_ld_done,
  output logic [NCH-1:0] dma_rd_req,
  output logic [NCH-1:0] dma_wr_req
);

  logic [NCH-1:0] rd_hold_q, wr_hold_q;
  logic [NCH-1:0] rd_req_q, wr_req_q;
  logic [NCH-1:0] rd_go, wr_go;

  assign rd_go = chan_en & rd_dma_en & rx_full  & ~rx_rd_done & ~rd_hold_q;
  assign wr_go = chan_en & wr_dma_en & tx_empty & ~tx_ld_done & ~wr_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold_q <= '0;
      wr_hold_q <= '0;
      rd_req_q  <= '0;
      wr_req_q  <= '0;
    end else begin
      rd_hold_q <= rx_rd_done;
      wr_hold_q <= tx_ld_done;
      rd_req_q  <= rd_go;
      wr_req_q  <= wr_go;
    end
  end

  assign dma_rd_req = rd_req_q;
  assign dma_wr_req = wr_req_q;

endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] rd_dma_en,
  input logic [NCH-1:0] wr_dma_en,
  input logic [NCH-1:0] rx_full,
  input logic [NCH-1:0] tx_empty,
  input logic [NCH-1:0] rx_rd_done,
  input logic [NCH-1:0] tx_ld_done,
  input logic [NCH-1:0] dma_rd_req,
  input logic [NCH-1:0] dma_wr_req
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (dma_rd_req == '0 && dma_wr_req == '0); // R1
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_RD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rd_req[i] |-> $past(chan_en[i] && rd_dma_en[i] && rx_full[i])); // R4
    AST_WR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_wr_req[i] |-> $past(chan_en[i] && wr_dma_en[i] && tx_empty[i])); // R5
    AST_RD_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en[i] && rd_dma_en[i] && rx_full[i] && !rx_rd_done[i] && !$past(rx_rd_done[i]))
      |=> dma_rd_req[i]); // R2
    AST_WR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en[i] && wr_dma_en[i] && tx_empty[i] && !tx_ld_done[i] && !$past(tx_ld_done[i]))
      |=> dma_wr_req[i]); // R3
    AST_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[i] |=> (!dma_rd_req[i] && !dma_wr_req[i])); // R6
    AST_RD_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd_done[i] |=> !dma_rd_req[i] ##1 !dma_rd_req[i]); // R7
    AST_WR_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ld_done[i] |=> !dma_wr_req[i] ##1 !dma_wr_req[i]); // R8
  end

endmodule

bind dma_req_gen dma_req_gen_chk #(.NCH(NCH)) chk_i (.*);

// File: tb/dma_req_gen_tb.sv
module dma_req_gen_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] chan_en, rd_dma_en, wr_dma_en, rx_full, tx_empty, rx_rd_done, tx_ld_done;
  logic [NCH-1:0] dma_rd_req, dma_wr_req;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_req_gen #(.NCH(NCH)) dut_i (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    chan_en = '0; rd_dma_en = '0; wr_dma_en = '0; rx_full = '0;
    tx_empty = '0; rx_rd_done = '0; tx_ld_done = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    idle();
    chan_en = '1; rd_dma_en = '1; wr_dma_en = '1; rx_full = '1; tx_empty = '1;
    step(2);
    chk(dma_rd_req == '0 && dma_wr_req == '0, "R1 in reset", dma_rd_req | dma_wr_req, '0);
    idle();
    rst_n = 1'b1;
    step(1);
    chk(dma_rd_req == '0 && dma_wr_req == '0, "R1 after release", dma_rd_req | dma_wr_req, '0);
  endtask

  task automatic t_read_basic();
    idle();
    chan_en = 4'b0001; rd_dma_en = 4'b0001; rx_full = 4'b0001;
    step(1);
    chk(dma_rd_req == 4'b0001, "R2 read raise", dma_rd_req, 4'b0001);
    chk(dma_wr_req == 4'b0000, "R2 no write", dma_wr_req, 4'b0000);
    rx_full = '0;
    step(1);
    chk(dma_rd_req == 4'b0000, "R2 data gone", dma_rd_req, 4'b0000);
  endtask

  task automatic t_write_basic();
    idle();
    chan_en = 4'b0010; wr_dma_en = 4'b0010; tx_empty = 4'b0010;
    step(1);
    chk(dma_wr_req == 4'b0010, "R3 write raise", dma_wr_req, 4'b0010);
    chk(dma_rd_req == 4'b0000, "R3 no read", dma_rd_req, 4'b0000);
  endtask

  task automatic t_masks();
    idle();
    chan_en = 4'b1111; rd_dma_en = 4'b1111; wr_dma_en = 4'b1111;
    rx_full = 4'b1111; tx_empty = 4'b1111;
    step(1);
    chk(dma_rd_req == 4'b1111, "R4 all read", dma_rd_req, 4'b1111);
    rd_dma_en = 4'b1011;
    step(1);
    chk(dma_rd_req == 4'b1011, "R4 read mask", dma_rd_req, 4'b1011);
    wr_dma_en = 4'b0111;
    step(1);
    chk(dma_wr_req == 4'b0111, "R5 write mask", dma_wr_req, 4'b0111);
  endtask

  task automatic t_disable();
    chan_en = 4'b1101;
    step(1);
    chk(dma_rd_req == 4'b1001, "R6 read off", dma_rd_req, 4'b1001);
    chk(dma_wr_req == 4'b0101, "R6 write off", dma_wr_req, 4'b0101);
  endtask

  task automatic t_read_done();
    idle();
    chan_en = 4'b0101; rd_dma_en = 4'b0101; rx_full = 4'b0101;
    step(1);
    rx_rd_done = 4'b0001;
    step(1);
    rx_rd_done = '0;
    chk(dma_rd_req == 4'b0100, "R7 first edge", dma_rd_req, 4'b0100);
    step(1);
    chk(dma_rd_req == 4'b0100, "R7 second edge", dma_rd_req, 4'b0100);
    step(1);
    chk(dma_rd_req == 4'b0101, "R7 return", dma_rd_req, 4'b0101);
  endtask

  task automatic t_write_done();
    idle();
    chan_en = 4'b1000; wr_dma_en = 4'b1000; tx_empty = 4'b1000;
    step(1);
    tx_ld_done = 4'b1000;
    step(1);
    tx_ld_done = '0;
    chk(dma_wr_req == 4'b0000, "R8 first edge", dma_wr_req, 4'b0000);
    step(1);
    chk(dma_wr_req == 4'b0000, "R8 second edge", dma_wr_req, 4'b0000);
    step(1);
    chk(dma_wr_req == 4'b1000, "R8 return", dma_wr_req, 4'b1000);
  endtask

  task automatic t_indep();
    idle();
    chan_en = 4'b0011; rd_dma_en = 4'b0010; wr_dma_en = 4'b0010;
    rx_full = 4'b0010; tx_empty = 4'b0010;
    step(1);
    chan_en = 4'b0010;
    rx_rd_done = 4'b0001; tx_ld_done = 4'b0001; rx_full = 4'b0011;
    for (int k = 0; k < 3; k++) begin
      step(1);
      rx_rd_done = '0; tx_ld_done = '0;
      chk(dma_rd_req == 4'b0010 && dma_wr_req == 4'b0010, "R9 neighbour steady",
          dma_rd_req | dma_wr_req, 4'b0010);
    end
  endtask

  initial begin
    t_reset();
    t_read_basic();
    t_write_basic();
    t_masks();
    t_disable();
    t_read_done();
    t_write_done();
    t_indep();
    summary();
  end

  initial begin
    #20000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule